// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flags

This block is the arithmetic and logic core of an 8-bit accumulator machine. It is purely combinational. Each operation takes an accumulator byte, an operand byte, a separate carry-in and the current flag byte. It returns a result byte and a new flag byte. One code also adds two 16-bit register pairs and returns their sum on a separate pair output.

Every operation rebuilds the whole flag byte, not only the documented bits. Bits 3 and 5 are copies of the result. Bit 2 is shared: the arithmetic operations put signed overflow there and the logic operations put parity there. Each operation also has its own rule for which old flags it keeps. The surrounding datapath decides where the result goes. For the 8-bit add, subtract and logic codes the result is the new accumulator. For increment and decrement it is the adjusted operand. For compare and the pair add the accumulator comes back unchanged.

Top module: `acc_alu`

## Requirements
- R1: Flag byte layout: bit 7 sign, bit 6 zero, bit 5 copy, bit 4 half-carry, bit 3 copy, bit 2 parity/overflow, bit 1 subtract marker N, bit 0 carry. For all 8-bit codes, bits 7, 5 and 3 equal bits 7, 5 and 3 of the computed 8-bit result. For compare, the computed result is the difference, not the returned byte.
- R2: ADD (code 0) and ADC (code 1) return acc+operand (+carry_in for ADC only) truncated to 8 bits. Half-carry is set when the low nibbles plus the carry term exceed 15. Overflow is set when both inputs share a sign bit and the result's sign differs. Carry is bit 8 of the 9-bit sum. N is 0.
- R3: SUB (code 2) and SBC (code 3) return acc-operand (-carry_in for SBC only) truncated to 8 bits. N is 1. Half-carry is set when acc's low nibble is less than the operand's low nibble plus the borrow term. Overflow is set when the inputs differ in sign and the result's sign differs from acc's. Carry is bit 8 of the 9-bit difference.
- R4: CMP (code 4) produces the same flags as SUB of the same inputs and returns acc unchanged.
- R5: AND (code 5), XOR (code 6) and OR (code 7) return the bitwise result and clear N and carry. Half-carry is 1 for AND and 0 for XOR and OR. Bit 2 is 1 when the result has an even number of set bits.
- R6: INC (code 8) returns operand+1 truncated to 8 bits. It keeps carry from the flag input and clears N. Half-carry is set when the result's low nibble is 0. Overflow is set when the result is 0x80.
- R7: DEC (code 9) returns operand-1 truncated to 8 bits. It keeps carry from the flag input and sets N. Half-carry is set when the operand's low nibble was 0. Overflow is set when the result is 0x7F.
- R8: PAIR ADD (code 10) returns pair_a+pair_b truncated to 16 bits on the pair output and returns acc unchanged. Bits 7, 6 and 2 keep their input values and N is cleared. Half-carry is the carry out of bit 11 and carry is the carry out of bit 15. Bits 5 and 3 are bits 13 and 11 of the sum. For every other code, the pair output equals pair_a.
- R9: For all 8-bit codes the zero flag is 1 exactly when the computed 8-bit result is 0.
- R10: Codes 11 to 15 are unused. They return acc and the flag input unchanged, and the pair output equals pair_a.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (0 to 10 defined, 11 to 15 pass-through) |
| acc_in | input | 8 | Accumulator byte |
| opnd_in | input | 8 | Operand byte (the value adjusted by INC/DEC) |
| carry_in | input | 1 | Carry or borrow term, used by ADC and SBC only |
| flags_in | input | 8 | Current flag byte |
| pair_a | input | 16 | Destination register pair for the pair add |
| pair_b | input | 16 | Source register pair for the pair add |
| acc_out | output | 8 | Result byte |
| flags_out | output | 8 | New flag byte |
| pair_out | output | 16 | Pair sum for code 10, otherwise pair_a |

## Verification
The checker enforces several properties on every input change:
- the copy and zero bits agree with the result byte;
- the subtract marker is set or cleared as each code requires;
- parity holds for the logic codes;
- compare and the pair add leave the accumulator alone;
- increment and decrement keep the old carry;
- the pair add keeps the preserved flags;
- unused codes pass every input through.

Some things only the bench scenarios can show. These are the exact half-carry and overflow values, the carry out of each width, and the difference-based copy bits of compare. They are checked against an independent integer reference over a sweep of every accumulator value and varied operands, and against a directed table at the nibble and sign boundaries.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DATA_W = 8;
    localparam int PAIR_W = 16;
    localparam int OP_W   = 4;
    localparam int NIB_W  = 4;

    localparam int FLG_C  = 0;
    localparam int FLG_N  = 1;
    localparam int FLG_PV = 2;
    localparam int FLG_X3 = 3;
    localparam int FLG_H  = 4;
    localparam int FLG_X5 = 5;
    localparam int FLG_Z  = 6;
    localparam int FLG_S  = 7;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 4'd0,
        OP_ADC   = 4'd1,
        OP_SUB   = 4'd2,
        OP_SBC   = 4'd3,
        OP_CMP   = 4'd4,
        OP_AND   = 4'd5,
        OP_XOR   = 4'd6,
        OP_OR    = 4'd7,
        OP_INC   = 4'd8,
        OP_DEC   = 4'd9,
        OP_ADD16 = 4'd10
    } alu_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [7:0]        flg;
    } alu_out_t;

    function automatic logic even_parity(input logic [DATA_W-1:0] v);
        return ~(^v);
    endfunction

    // Assemble the flag byte: sign, zero and copy bits come from the result.
    function automatic logic [7:0] build_flags(input logic [DATA_W-1:0] r,
                                               input logic h,
                                               input logic pv,
                                               input logic n,
                                               input logic c);
        logic [7:0] f;
        f         = '0;
        f[FLG_S]  = r[7];
        f[FLG_Z]  = (r == '0);
        f[FLG_X5] = r[5];
        f[FLG_H]  = h;
        f[FLG_X3] = r[3];
        f[FLG_PV] = pv;
        f[FLG_N]  = n;
        f[FLG_C]  = c;
        return f;
    endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
    import acc_alu_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              is_sub,
    output alu_out_t          out
);
    localparam int EXT_W = DATA_W + 1;
    localparam int NEX_W = NIB_W + 1;

    logic [EXT_W-1:0] wide;
    logic [NEX_W-1:0] nib;
    logic [DATA_W-1:0] r;
    logic              ovf;

    always_comb begin
        if (is_sub) begin
            wide = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};
            nib  = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]} - {{NIB_W{1'b0}}, cin};
        end else begin
            wide = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
            nib  = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
        end
        r = wide[DATA_W-1:0];
        if (is_sub)
            ovf = (a[DATA_W-1] != b[DATA_W-1]) && (r[DATA_W-1] != a[DATA_W-1]);
        else
            ovf = (a[DATA_W-1] == b[DATA_W-1]) && (r[DATA_W-1] != a[DATA_W-1]);
        out.res = r;
        out.flg = build_flags(r, nib[NIB_W], ovf, is_sub, wide[DATA_W]);
    end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  alu_op_e           op,
    output alu_out_t          out
);
    logic [DATA_W-1:0] r;

    always_comb begin
        unique case (op)
            OP_AND:  r = a & b;
            OP_XOR:  r = a ^ b;
            default: r = a | b;
        endcase
        out.res = r;
        out.flg = build_flags(r, op == OP_AND, even_parity(r), 1'b0, 1'b0);
    end

endmodule

// File: rtl/acc_alu_incdec.sv
module acc_alu_incdec
    import acc_alu_pkg::*;
(
    input  logic [DATA_W-1:0] val,
    input  logic              is_dec,
    input  logic              old_c,
    output alu_out_t          out
);
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};

    logic [DATA_W-1:0] r;
    logic              h;
    logic              ovf;

    always_comb begin
        if (is_dec) begin
            r   = val - 1'b1;
            h   = (val[NIB_W-1:0] == '0);
            ovf = (val == MOST_NEG);
        end else begin
            r   = val + 1'b1;
            h   = (val[NIB_W-1:0] == '1);
            ovf = (val == MOST_POS);
        end
        out.res = r;
        out.flg = build_flags(r, h, ovf, is_dec, old_c);
    end

endmodule

// File: rtl/acc_alu_pair_add.sv
module acc_alu_pair_add
    import acc_alu_pkg::*;
#(
    parameter int W = PAIR_W
) (
    input  logic [W-1:0] pa,
    input  logic [W-1:0] pb,
    input  logic [2:0]   kept,     // old sign, zero, parity/overflow
    output logic [W-1:0] sum,
    output logic [7:0]   flg
);
    localparam int NIBS = W / NIB_W;

    logic [NIBS:0] cy;

    assign cy[0] = 1'b0;

    for (genvar g = 0; g < NIBS; g++) begin : g_nib
        logic [NIB_W:0] part;
        assign part = {1'b0, pa[g*NIB_W +: NIB_W]} + {1'b0, pb[g*NIB_W +: NIB_W]}
                    + {{NIB_W{1'b0}}, cy[g]};
        assign sum[g*NIB_W +: NIB_W] = part[NIB_W-1:0];
        assign cy[g+1] = part[NIB_W];
    end

    always_comb begin
        flg         = '0;
        flg[FLG_S]  = kept[2];
        flg[FLG_Z]  = kept[1];
        flg[FLG_PV] = kept[0];
        flg[FLG_X5] = sum[W-3];
        flg[FLG_X3] = sum[W-5];
        flg[FLG_H]  = cy[NIBS-1];
        flg[FLG_N]  = 1'b0;
        flg[FLG_C]  = cy[NIBS];
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic              carry_in,
    input  logic [7:0]        flags_in,
    input  logic [PAIR_W-1:0] pair_a,
    input  logic [PAIR_W-1:0] pair_b,
    output logic [DATA_W-1:0] acc_out,
    output logic [7:0]        flags_out,
    output logic [PAIR_W-1:0] pair_out
);
    alu_op_e           op;
    logic              as_sub;
    logic              as_cin;
    alu_out_t          as_out;
    alu_out_t          lg_out;
    alu_out_t          id_out;
    logic [PAIR_W-1:0] pr_sum;
    logic [7:0]        pr_flg;

    assign op     = alu_op_e'(op_sel);
    assign as_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
    assign as_cin = ((op == OP_ADC) || (op == OP_SBC)) ? carry_in : 1'b0;

    acc_alu_addsub u_addsub (
        .a      (acc_in),
        .b      (opnd_in),
        .cin    (as_cin),
        .is_sub (as_sub),
        .out    (as_out)
    );

    acc_alu_logic u_logic (
        .a   (acc_in),
        .b   (opnd_in),
        .op  (op),
        .out (lg_out)
    );

    acc_alu_incdec u_incdec (
        .val    (opnd_in),
        .is_dec (op == OP_DEC),
        .old_c  (flags_in[FLG_C]),
        .out    (id_out)
    );

    acc_alu_pair_add #(.W(PAIR_W)) u_pair (
        .pa   (pair_a),
        .pb   (pair_b),
        .kept ({flags_in[FLG_S], flags_in[FLG_Z], flags_in[FLG_PV]}),
        .sum  (pr_sum),
        .flg  (pr_flg)
    );

    always_comb begin
        acc_out   = acc_in;
        flags_out = flags_in;
        pair_out  = pair_a;
        case (op_sel)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                acc_out   = as_out.res;
                flags_out = as_out.flg;
            end
            OP_CMP: begin
                flags_out = as_out.flg;
            end
            OP_AND, OP_XOR, OP_OR: begin
                acc_out   = lg_out.res;
                flags_out = lg_out.flg;
            end
            OP_INC, OP_DEC: begin
                acc_out   = id_out.res;
                flags_out = id_out.flg;
            end
            OP_ADD16: begin
                flags_out = pr_flg;
                pair_out  = pr_sum;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker
    import acc_alu_pkg::*;
(
    input logic [OP_W-1:0]   op_sel,
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] opnd_in,
    input logic              carry_in,
    input logic [7:0]        flags_in,
    input logic [PAIR_W-1:0] pair_a,
    input logic [PAIR_W-1:0] pair_b,
    input logic [DATA_W-1:0] acc_out,
    input logic [7:0]        flags_out,
    input logic [PAIR_W-1:0] pair_out
);
    logic byte_op;
    logic [DATA_W-1:0] back_sum;

    assign byte_op  = (op_sel <= 4'd9) && (op_sel != 4'd4);
    assign back_sum = acc_out + opnd_in + {{(DATA_W-1){1'b0}}, carry_in};

    always_comb begin
        if (!$isunknown({op_sel, acc_in, opnd_in, carry_in, flags_in, pair_a, pair_b})) begin
            if (byte_op) begin
                a_r1_copy_bits: assert (flags_out[7] == acc_out[7] &&
                                        flags_out[5] == acc_out[5] &&
                                        flags_out[3] == acc_out[3])
                    else $error("copy bits differ from result");
                a_r9_zero_flag: assert (flags_out[6] == (acc_out == '0))
                    else $error("zero flag wrong");
            end
            if (op_sel == 4'd0 || op_sel == 4'd1) begin
                a_r2_add_n_clear: assert (!flags_out[1] &&
                                          (!flags_out[2] || acc_in[7] == opnd_in[7]))
                    else $error("add flags wrong");
            end
            if (op_sel == 4'd3) begin
                a_r3_sbc_inverts: assert (back_sum == acc_in && flags_out[1])
                    else $error("sbc result wrong");
            end
            if (op_sel == 4'd2 || op_sel == 4'd4) begin
                a_r3_sub_n_set: assert (flags_out[1])
                    else $error("subtract marker clear");
            end
            if (op_sel == 4'd4) begin
                a_r4_cmp_keeps_acc: assert (acc_out == acc_in)
                    else $error("compare changed accumulator");
            end
            if (op_sel >= 4'd5 && op_sel <= 4'd7) begin
                a_r5_logic_parity: assert (flags_out[2] == even_parity(acc_out) &&
                                           !flags_out[1] && !flags_out[0])
                    else $error("logic flags wrong");
            end
            if (op_sel == 4'd8) begin
                a_r6_inc_keeps_carry: assert (flags_out[0] == flags_in[0] && !flags_out[1])
                    else $error("increment carry or N wrong");
            end
            if (op_sel == 4'd9) begin
                a_r7_dec_keeps_carry: assert (flags_out[0] == flags_in[0] && flags_out[1])
                    else $error("decrement carry or N wrong");
            end
            if (op_sel == 4'd10) begin
                a_r8_pair_keeps: assert (acc_out == acc_in && !flags_out[1] &&
                                         flags_out[7] == flags_in[7] &&
                                         flags_out[6] == flags_in[6] &&
                                         flags_out[2] == flags_in[2] &&
                                         pair_out - pair_b == pair_a)
                    else $error("pair add wrong");
            end else begin
                a_r8_pair_passes: assert (pair_out == pair_a)
                    else $error("pair output moved");
            end
            if (op_sel >= 4'd11) begin
                a_r10_pass_through: assert (acc_out == acc_in && flags_out == flags_in)
                    else $error("unused code changed state");
            end
        end
    end

endmodule

bind acc_alu acc_alu_checker chk_i (.*);

// File: tb/acc_alu_tb_top.sv
`timescale 1ns/1ps
module acc_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_sel;
    logic [7:0]  acc_in, opnd_in, flags_in;
    logic        carry_in;
    logic [15:0] pair_a, pair_b;
    logic [7:0]  acc_out, flags_out;
    logic [15:0] pair_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    acc_alu dut_i (
        .op_sel    (op_sel),
        .acc_in    (acc_in),
        .opnd_in   (opnd_in),
        .carry_in  (carry_in),
        .flags_in  (flags_in),
        .pair_a    (pair_a),
        .pair_b    (pair_b),
        .acc_out   (acc_out),
        .flags_out (flags_out),
        .pair_out  (pair_out)
    );

    typedef struct packed {
        logic [7:0]  res;
        logic [7:0]  flg;
        logic [15:0] pair;
    } exp_t;

    typedef struct packed {
        logic [3:0]  op;
        logic [7:0]  a;
        logic [7:0]  b;
        logic        ci;
        logic [7:0]  fi;
        logic [15:0] pa;
        logic [15:0] pb;
        logic [7:0]  xres;
        logic [7:0]  xflg;
        logic [15:0] xpair;
    } vec_t;

    localparam int NVEC = 20;
    localparam vec_t VECS [NVEC] = '{
        '{4'd0,  8'h7F, 8'h01, 1'b0, 8'h00, 16'h0000, 16'h0000, 8'h80, 8'h94, 16'h0000},
        '{4'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 16'h0000, 16'h0000, 8'h00, 8'h51, 16'h0000},
        '{4'd0,  8'h10, 8'h10, 1'b1, 8'h00, 16'h0000, 16'h0000, 8'h20, 8'h20, 16'h0000},
        '{4'd0,  8'h80, 8'h80, 1'b0, 8'h00, 16'h0000, 16'h0000, 8'h00, 8'h45, 16'h0000}, // R9 wrap to zero
        '{4'd1,  8'h0F, 8'h00, 1'b1, 8'h00, 16'h0000, 16'h0000, 8'h10, 8'h10, 16'h0000},
        '{4'd2,  8'h00, 8'h01, 1'b0, 8'h00, 16'h0000, 16'h0000, 8'hFF, 8'hBB, 16'h0000},
        '{4'd3,  8'h80, 8'h00, 1'b1, 8'h00, 16'h0000, 16'h0000, 8'h7F, 8'h3E, 16'h0000},
        '{4'd4,  8'h42, 8'h42, 1'b0, 8'h00, 16'h0000, 16'h0000, 8'h42, 8'h42, 16'h0000},
        '{4'd4,  8'h00, 8'h01, 1'b0, 8'h00, 16'h0000, 16'h0000, 8'h00, 8'hBB, 16'h0000}, // R1 copy bits from difference
        '{4'd5,  8'hF0, 8'h3C, 1'b0, 8'h00, 16'h0000, 16'h0000, 8'h30, 8'h34, 16'h0000},
        '{4'd6,  8'h55, 8'h55, 1'b0, 8'h00, 16'h0000, 16'h0000, 8'h00, 8'h44, 16'h0000},
        '{4'd7,  8'h01, 8'h02, 1'b0, 8'hFF, 16'h0000, 16'h0000, 8'h03, 8'h04, 16'h0000},
        '{4'd8,  8'h33, 8'h7F, 1'b0, 8'h01, 16'h0000, 16'h0000, 8'h80, 8'h95, 16'h0000},
        '{4'd9,  8'h33, 8'h80, 1'b0, 8'h00, 16'h0000, 16'h0000, 8'h7F, 8'h3E, 16'h0000},
        '{4'd9,  8'h33, 8'h01, 1'b0, 8'h01, 16'h0000, 16'h0000, 8'h00, 8'h43, 16'h0000},
        '{4'd10, 8'h11, 8'h00, 1'b0, 8'hFF, 16'h0FFF, 16'h0001, 8'h11, 8'hD4, 16'h1000},
        '{4'd10, 8'h11, 8'h00, 1'b0, 8'h00, 16'hFFFF, 16'h0001, 8'h11, 8'h11, 16'h0000},
        '{4'd10, 8'h11, 8'h00, 1'b0, 8'h00, 16'h2800, 16'h0000, 8'h11, 8'h28, 16'h2800},
        '{4'd15, 8'h12, 8'h00, 1'b1, 8'hA5, 16'hBEEF, 16'h0000, 8'h12, 8'hA5, 16'hBEEF},
        '{4'd11, 8'h9C, 8'hFF, 1'b0, 8'h3A, 16'h1234, 16'hFFFF, 8'h9C, 8'h3A, 16'h1234}
    };

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:       return "R2";
            4'd2, 4'd3:       return "R3";
            4'd4:             return "R4";
            4'd5, 4'd6, 4'd7: return "R5";
            4'd8:             return "R6";
            4'd9:             return "R7";
            4'd10:            return "R8";
            default:          return "R10";
        endcase
    endfunction

    function automatic logic [7:0] mk(input logic [7:0] r, input logic h,
                                      input logic pv, input logic n, input logic c);
        return {r[7], (r == 8'h00), r[5], h, r[3], pv, n, c};
    endfunction

    // Integer reference model (R1 to R10)
    function automatic exp_t ref_model(input logic [3:0] op, input logic [7:0] a,
                                       input logic [7:0] b, input logic ci,
                                       input logic [7:0] fi, input logic [15:0] pa,
                                       input logic [15:0] pb);
        exp_t e;
        int ia, ib, ic, s, sa, sb, sv, cnt;
        logic [7:0] r;
        logic [15:0] ps;
        logic h, v;
        e.res = a; e.flg = fi; e.pair = pa;
        ia = int'(a); ib = int'(b);
        sa = (ia > 127) ? ia - 256 : ia;
        sb = (ib > 127) ? ib - 256 : ib;
        case (op)
            4'd0, 4'd1: begin
                ic = (op == 4'd1) ? int'(ci) : 0;
                s = ia + ib + ic; r = 8'(s);
                h = ((ia % 16) + (ib % 16) + ic) > 15;
                sv = sa + sb + ic; v = (sv > 127) || (sv < -128);
                e.res = r; e.flg = mk(r, h, v, 1'b0, s > 255);
            end
            4'd2, 4'd3, 4'd4: begin
                ic = (op == 4'd3) ? int'(ci) : 0;
                s = ia - ib - ic; r = 8'(s);
                h = (ia % 16) < ((ib % 16) + ic);
                sv = sa - sb - ic; v = (sv > 127) || (sv < -128);
                e.flg = mk(r, h, v, 1'b1, s < 0);
                if (op != 4'd4) e.res = r;
            end
            4'd5, 4'd6, 4'd7: begin
                r = (op == 4'd5) ? (a & b) : (op == 4'd6) ? (a ^ b) : (a | b);
                cnt = 0;
                for (int k = 0; k < 8; k++) cnt += int'(r[k]);
                e.res = r; e.flg = mk(r, op == 4'd5, (cnt % 2) == 0, 1'b0, 1'b0);
            end
            4'd8: begin
                r = 8'(ib + 1);
                e.res = r; e.flg = mk(r, (int'(r) % 16) == 0, r == 8'h80, 1'b0, fi[0]);
            end
            4'd9: begin
                r = 8'(ib - 1);
                e.res = r; e.flg = mk(r, (ib % 16) == 0, r == 8'h7F, 1'b1, fi[0]);
            end
            4'd10: begin
                s = int'(pa) + int'(pb); ps = 16'(s);
                h = ((int'(pa) % 4096) + (int'(pb) % 4096)) > 4095;
                e.pair = ps;
                e.flg = {fi[7], fi[6], ps[13], h, ps[11], fi[2], 1'b0, s > 65535};
            end
            default: ;
        endcase
        return e;
    endfunction

    task automatic apply_and_check(input logic [3:0] op, input logic [7:0] a,
                                   input logic [7:0] b, input logic ci,
                                   input logic [7:0] fi, input logic [15:0] pa,
                                   input logic [15:0] pb, input exp_t e, input string req);
        @(posedge clk);
        #1;
        op_sel = op; acc_in = a; opnd_in = b; carry_in = ci;
        flags_in = fi; pair_a = pa; pair_b = pb;
        @(negedge clk);
        checks++;
        if (acc_out !== e.res || flags_out !== e.flg || pair_out !== e.pair) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h ci=%0d fi=%h: got res=%h flg=%h pair=%h expected res=%h flg=%h pair=%h",
                     req, op, a, b, ci, fi, acc_out, flags_out, pair_out, e.res, e.flg, e.pair);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_t e;
        logic [7:0] b;
        op_sel = 4'hF; acc_in = 8'h00; opnd_in = 8'h00; carry_in = 1'b0;
        flags_in = 8'h00; pair_a = 16'h0000; pair_b = 16'h0000;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10: reset state with a pass-through code
        checks++;
        if (acc_out !== 8'h00 || flags_out !== 8'h00 || pair_out !== 16'h0000) begin
            errors++;
            $display("FAIL R10 reset state: got %h %h %h expected 00 00 0000",
                     acc_out, flags_out, pair_out);
        end
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            e.res = VECS[i].xres; e.flg = VECS[i].xflg; e.pair = VECS[i].xpair;
            apply_and_check(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].ci, VECS[i].fi,
                            VECS[i].pa, VECS[i].pb, e, req_of(VECS[i].op));
        end

        // Sweep against the reference; R1 and R9 are covered inside every byte code
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int bi = 0; bi < ((op <= 10) ? 16 : 3); bi++) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        logic [7:0] av, fi;
                        logic [15:0] pa, pb;
                        av = 8'(a);
                        if (op <= 10) b = 8'(bi * 17);
                        else b = (bi == 0) ? 8'h00 : (bi == 1) ? 8'h5A : 8'hFF;
                        fi = av ^ {b[3:0], b[7:4]} ^ 8'(ci * 8'h81);
                        pa = {av, b ^ 8'h3C};
                        pb = {b, av ^ 8'(ci * 8'hF0)};
                        e = ref_model(4'(op), av, b, 1'(ci), fi, pa, pb);
                        apply_and_check(4'(op), av, b, 1'(ci), fi, pa, pb, e, req_of(4'(op)));
                    end
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule